// File: doc/BRIEF.md
# DRAM Timing Configuration Register File

This block is a bus-slave register file that holds the programmable timing and mode settings of a DRAM controller core. Software writes 28 words of 32 bits each. The first 21 are timing control words and the last 7 are mode words. The core sees every stored word at once on a wide parallel output, so no read port is shared.

Each stored word has an "updated" flag. The flag rises when software writes that word. It stays high until the core acknowledges the index, which lets the core know which settings to reload into its timing counters.

The core also reports the outcome of each memory read or write through a small strobe. The block collects these reports into a status word that software can read. The bus side uses the usual two-phase select/enable handshake with zero wait states. Illegal accesses are flagged with an error response.

Top module: `dram_timing_regs`

## Requirements
- R1: After synchronous reset (`rst` high at a rising clock edge) every stored word, every updated flag and the status word are 0.
- R2: Word i sits at byte address 4*i. Indices 0 to 20 are timing words and indices 21 to 27 are mode words. A write with `bus_sel`, `bus_en` and `bus_write` high at a rising edge stores `bus_wdata` into the addressed word. `bus_ready` is high in every access phase, so no wait states are inserted.
- R3: Reserved bits ignore writes and read as 0. These are bits [31:30] of word 0, bits [31:28] of word 2, and bits [31:18] of every mode word. All other bits of every word are writable.
- R4: A read returns the addressed content on `bus_rdata` during the access phase. Reads never change the updated flags.
- R5: An accepted write to word i sets updated flag i at the same edge that stores the data.
- R6: A pulse on `core_ack_valid` with index `core_ack_idx` clears that flag at the next edge. If a bus write to the same index commits at that same edge, the write wins and the flag stays 1.
- R7: The following accesses assert `bus_err` in the access phase, return 0 on reads, and change no state: misaligned addresses (addr[1:0] not 0), any index above 29, and writes to index 28 or 29.
- R8: Index 28 reads the updated flags, with flag i in bit i. Index 29 reads the core status word:
  - bit0 is the outcome of the last read report and bit1 the outcome of the last write report (1 = success);
  - bit2 is set once any read has been reported and bit3 once any write has been reported;
  - bits [15:8] count failures and saturate at 255.
- R9: `cfg_flat[32*i+31:32*i]` always shows stored word i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Slave select |
| bus_en | input | 1 | Access-phase enable |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data |
| bus_ready | output | 1 | Transfer complete |
| bus_err | output | 1 | Error response |
| cfg_flat | output | 896 | All stored words, word i at bits [32i+31:32i] |
| upd_flags | output | 28 | Updated flag per word |
| core_ack_valid | input | 1 | Core acknowledge strobe |
| core_ack_idx | input | 5 | Index being acknowledged |
| core_rep_valid | input | 1 | Core outcome report strobe |
| core_rep_is_wr | input | 1 | Report concerns a write (1) or read (0) |
| core_rep_ok | input | 1 | Reported access succeeded |

## Verification
The assertions assume that the bus master follows the two-phase protocol. A setup cycle with `bus_en` low always precedes the access cycle. Address, direction and write data stay stable across both cycles, and `bus_en` never rises without `bus_sel`. They also assume that an acknowledge index is either below 28 or is harmless. The directed bench drives every transfer through one task that produces exactly this setup-then-access sequence on falling edges. Its acknowledge and report strobes use only legal indices and last one cycle each, except where a test deliberately overlaps an acknowledge with a write commit.

// File: rtl/dram_timing_pkg.sv
package dram_timing_pkg;
  localparam int WORD_W = 32;

  // Writable-bit mask of stored word idx; reserved bits are 0.
  function automatic logic [WORD_W-1:0] field_mask(input int idx, input int n_ctrl,
                                                   input int mode_w);
    logic [WORD_W-1:0] m;
    if (idx >= n_ctrl)   m = (WORD_W'(1) << mode_w) - WORD_W'(1);
    else if (idx == 0)   m = 32'h3FFF_FFFF;
    else if (idx == 2)   m = 32'h0FFF_FFFF;
    else                 m = '1;
    return m;
  endfunction
endpackage

// File: rtl/drt_bus_if.sv
module drt_bus_if #(
  parameter int ADDR_W = 8,
  parameter int N_CFG  = 28,
  parameter int IDX_W  = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sel,
  input  logic                 en,
  input  logic                 write,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [N_CFG*32-1:0]  cfg_rd,
  input  logic [N_CFG-1:0]     flags_rd,
  input  logic [31:0]          stat_rd,
  output logic [31:0]          rdata,
  output logic                 ready,
  output logic                 err,
  output logic                 wr_en,
  output logic [IDX_W-1:0]     wr_idx
);
  localparam int WORD_AW = ADDR_W - 2;

  logic [WORD_AW-1:0] word;
  logic aligned, is_cfg, is_flags, is_stat, legal;
  logic [31:0] rd_mux;
  logic [31:0] rdata_q;
  logic        err_q;

  assign word     = addr[ADDR_W-1:2];
  assign aligned  = (addr[1:0] == 2'b00);
  assign is_cfg   = aligned && (int'(word) < N_CFG);
  assign is_flags = aligned && (int'(word) == N_CFG);
  assign is_stat  = aligned && (int'(word) == N_CFG + 1);
  assign legal    = write ? is_cfg : (is_cfg || is_flags || is_stat);

  always_comb begin
    rd_mux = '0;
    if (is_cfg) begin
      for (int i = 0; i < N_CFG; i++)
        if (int'(word) == i) rd_mux = cfg_rd[i*32 +: 32];
    end else if (is_flags) begin
      for (int i = 0; i < N_CFG; i++) rd_mux[i] = flags_rd[i];
    end else if (is_stat) begin
      rd_mux = stat_rd;
    end
  end

  // Response is captured in the setup cycle, presented in the access cycle.
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else if (sel && !en) begin
      rdata_q <= (write || !legal) ? 32'd0 : rd_mux;
      err_q   <= !legal;
    end else if (!sel) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end
  end

  assign rdata  = rdata_q;
  assign ready  = sel && en;
  assign err    = sel && en && err_q;
  assign wr_en  = sel && en && write && !err_q;
  assign wr_idx = word[IDX_W-1:0];

  // R2: zero-wait access always completes in the cycle after setup
  a_r2_ready_after_setup: assert property (@(posedge clk) disable iff (rst)
    (sel && !en) |=> (en |-> ready));
endmodule

// File: rtl/drt_reg_bank.sv
module drt_reg_bank
  import dram_timing_pkg::*;
#(
  parameter int N_CTRL = 21,
  parameter int N_MODE = 7,
  parameter int MODE_W = 18,
  parameter int IDX_W  = 5,
  localparam int N_CFG = N_CTRL + N_MODE
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [IDX_W-1:0]    wr_idx,
  input  logic [31:0]         wdata,
  output logic [N_CFG*32-1:0] cfg
);
  for (genvar g = 0; g < N_CFG; g++) begin : g_word
    localparam logic [31:0] MASK = field_mask(g, N_CTRL, MODE_W);
    logic [31:0] q;
    always_ff @(posedge clk) begin
      if (rst)                                   q <= '0;
      else if (wr_en && int'(wr_idx) == g)       q <= wdata & MASK;
    end
    assign cfg[g*32 +: 32] = q;

    // R3: reserved bits never hold a 1
    a_r3_reserved_zero: assert property (@(posedge clk) disable iff (rst)
      (q & ~MASK) == 32'd0);
  end

  // R7: storage moves only on an accepted write
  a_r7_no_stray_update: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(cfg));
endmodule

// File: rtl/drt_upd_flags.sv
module drt_upd_flags #(
  parameter int N_CFG = 28,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic             ack_valid,
  input  logic [IDX_W-1:0] ack_idx,
  output logic [N_CFG-1:0] flags
);
  for (genvar g = 0; g < N_CFG; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)                                      flags[g] <= 1'b0;
      else if (wr_en && int'(wr_idx) == g)          flags[g] <= 1'b1;
      else if (ack_valid && int'(ack_idx) == g)     flags[g] <= 1'b0;
    end
  end

  // R5: a committed write raises its flag
  a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_idx) < N_CFG) |=> flags[$past(wr_idx)]);
  // R6: an acknowledge without a colliding write clears the flag
  a_r6_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_valid && int'(ack_idx) < N_CFG && !(wr_en && wr_idx == ack_idx))
      |=> !flags[$past(ack_idx)]);
endmodule

// File: rtl/drt_core_status.sv
module drt_core_status #(
  parameter int FAIL_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rep_valid,
  input  logic        rep_is_wr,
  input  logic        rep_ok,
  output logic [31:0] stat
);
  logic rd_ok, wr_ok, rd_seen, wr_seen;
  logic [FAIL_W-1:0] fail_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_ok <= 1'b0; wr_ok <= 1'b0; rd_seen <= 1'b0; wr_seen <= 1'b0;
      fail_cnt <= '0;
    end else if (rep_valid) begin
      if (rep_is_wr) begin wr_ok <= rep_ok; wr_seen <= 1'b1; end
      else           begin rd_ok <= rep_ok; rd_seen <= 1'b1; end
      if (!rep_ok && fail_cnt != '1) fail_cnt <= fail_cnt + 1'b1;
    end
  end

  always_comb begin
    stat = '0;
    stat[0] = rd_ok;
    stat[1] = wr_ok;
    stat[2] = rd_seen;
    stat[3] = wr_seen;
    stat[8 +: FAIL_W] = fail_cnt;
  end

  // R8: last write outcome follows the report
  a_r8_wr_outcome: assert property (@(posedge clk) disable iff (rst)
    (rep_valid && rep_is_wr) |=> (wr_ok == $past(rep_ok)));
  // R8: failure counter saturates instead of wrapping
  a_r8_fail_saturates: assert property (@(posedge clk) disable iff (rst)
    (fail_cnt == '1) |=> (fail_cnt == '1));
endmodule

// File: rtl/dram_timing_regs.sv
module dram_timing_regs #(
  parameter int N_CTRL = 21,
  parameter int N_MODE = 7,
  parameter int MODE_W = 18,
  parameter int ADDR_W = 8,
  parameter int FAIL_W = 8,
  localparam int N_CFG = N_CTRL + N_MODE,
  localparam int IDX_W = $clog2(N_CFG + 2)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bus_sel,
  input  logic                bus_en,
  input  logic                bus_write,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  output logic                bus_ready,
  output logic                bus_err,
  output logic [N_CFG*32-1:0] cfg_flat,
  output logic [N_CFG-1:0]    upd_flags,
  input  logic                core_ack_valid,
  input  logic [IDX_W-1:0]    core_ack_idx,
  input  logic                core_rep_valid,
  input  logic                core_rep_is_wr,
  input  logic                core_rep_ok
);
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [31:0]      stat;

  drt_bus_if #(.ADDR_W(ADDR_W), .N_CFG(N_CFG), .IDX_W(IDX_W)) u_bus (
    .clk(clk), .rst(rst), .sel(bus_sel), .en(bus_en), .write(bus_write),
    .addr(bus_addr), .cfg_rd(cfg_flat), .flags_rd(upd_flags), .stat_rd(stat),
    .rdata(bus_rdata), .ready(bus_ready), .err(bus_err),
    .wr_en(wr_en), .wr_idx(wr_idx));

  drt_reg_bank #(.N_CTRL(N_CTRL), .N_MODE(N_MODE), .MODE_W(MODE_W), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wdata(bus_wdata),
    .cfg(cfg_flat));

  drt_upd_flags #(.N_CFG(N_CFG), .IDX_W(IDX_W)) u_flags (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .ack_valid(core_ack_valid), .ack_idx(core_ack_idx), .flags(upd_flags));

  drt_core_status #(.FAIL_W(FAIL_W)) u_stat (
    .clk(clk), .rst(rst), .rep_valid(core_rep_valid), .rep_is_wr(core_rep_is_wr),
    .rep_ok(core_rep_ok), .stat(stat));

  // R4: a read with no acknowledge leaves every flag as it was
  a_r4_read_keeps_flags: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_en && !bus_write && !core_ack_valid) |=> $stable(upd_flags));
  // R7: an error response never commits a write
  a_r7_err_no_flag: assert property (@(posedge clk) disable iff (rst)
    (bus_err && !core_ack_valid) |=> $stable(upd_flags));
endmodule

// File: tb/dram_timing_regs_tb.sv
module dram_timing_regs_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NC = 28;

  logic clk = 0, rst = 1;
  logic sel = 0, en = 0, wr = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic [31:0] rdata;
  logic ready, err;
  logic [NC*32-1:0] cfg_flat;
  logic [NC-1:0] flags;
  logic ack_v = 0;
  logic [4:0] ack_i = 0;
  logic rep_v = 0, rep_w = 0, rep_ok = 0;

  int nchk = 0, nerr = 0;
  logic [31:0] model [NC];
  logic [NC-1:0] exp_flags;

  always #(CLK_PERIOD/2) clk = ~clk;

  dram_timing_regs u_dut (
    .clk(clk), .rst(rst), .bus_sel(sel), .bus_en(en), .bus_write(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .bus_ready(ready),
    .bus_err(err), .cfg_flat(cfg_flat), .upd_flags(flags),
    .core_ack_valid(ack_v), .core_ack_idx(ack_i),
    .core_rep_valid(rep_v), .core_rep_is_wr(rep_w), .core_rep_ok(rep_ok));

  function automatic logic [31:0] bmask(int i);
    if (i == 0) return 32'h3FFF_FFFF;
    if (i == 2) return 32'h0FFF_FFFF;
    if (i >= 21) return 32'h0003_FFFF;
    return 32'hFFFF_FFFF;
  endfunction

  task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
    nchk++;
    if (got !== exp) begin
      nerr++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic xfer(logic w, logic [7:0] a, logic [31:0] d,
                      output logic [31:0] rd, output logic er, output logic rdy);
    @(negedge clk); sel = 1; en = 0; wr = w; addr = a; wdata = d;
    @(negedge clk); en = 1; #1; rdy = ready; er = err; rd = rdata;
    @(negedge clk); sel = 0; en = 0; wr = 0;
  endtask

  task automatic wr_reg(int i, logic [31:0] d);
    logic [31:0] rd; logic er, rdy;
    xfer(1, 8'(i*4), d, rd, er, rdy);
    chk("R2 ready", {63'd0, rdy}, 64'd1);
    chk("R2 no err", {63'd0, er}, 64'd0);
    model[i] = d & bmask(i);
    exp_flags[i] = 1'b1;
  endtask

  task automatic rd_addr(logic [7:0] a, output logic [31:0] rd, output logic er);
    logic rdy;
    xfer(0, a, 32'hDEAD_BEEF, rd, er, rdy);
  endtask

  function automatic logic [NC*32-1:0] model_flat();
    logic [NC*32-1:0] f;
    for (int i = 0; i < NC; i++) f[i*32 +: 32] = model[i];
    return f;
  endfunction

  task automatic t_reset();
    logic [31:0] rd; logic er;
    chk("R1 cfg zero", {63'd0, cfg_flat == '0}, 64'd1);
    chk("R1 flags zero", 64'(flags), 64'd0);
    rd_addr(8'h74, rd, er);
    chk("R1 status zero", 64'(rd), 64'd0);
    rd_addr(8'h14, rd, er);
    chk("R1 word5 zero", 64'(rd), 64'd0);
  endtask

  task automatic t_write_read();
    logic [31:0] rd; logic er;
    wr_reg(5, 32'hA5A5_1234);
    chk("R9 slice 5", 64'(cfg_flat[5*32 +: 32]), 64'hA5A5_1234);
    chk("R9 slice 4 untouched", 64'(cfg_flat[4*32 +: 32]), 64'd0);
    rd_addr(8'h14, rd, er);
    chk("R4 readback 5", 64'(rd), 64'hA5A5_1234);
    wr_reg(27, 32'h0001_2345);
    rd_addr(8'h6C, rd, er);
    chk("R2 last mode word", 64'(rd), 64'h0001_2345);
  endtask

  task automatic t_reserved();
    logic [31:0] rd; logic er;
    int idx [4] = '{0, 2, 21, 7};
    foreach (idx[k]) begin
      wr_reg(idx[k], 32'hFFFF_FFFF);
      rd_addr(8'(idx[k]*4), rd, er);
      chk("R3 reserved read", 64'(rd), 64'(bmask(idx[k])));
      chk("R3 reserved cfg", 64'(cfg_flat[idx[k]*32 +: 32]), 64'(bmask(idx[k])));
    end
  endtask

  task automatic t_flags();
    logic [31:0] rd; logic er;
    chk("R5 flags port", 64'(flags), 64'(exp_flags));
    rd_addr(8'h70, rd, er);
    chk("R8 flags word", 64'(rd), 64'(exp_flags));
    for (int k = 0; k < 3; k++) rd_addr(8'h14, rd, er);
    chk("R4 reads keep flags", 64'(flags), 64'(exp_flags));
  endtask

  task automatic t_ack();
    @(negedge clk); ack_v = 1; ack_i = 5;
    @(negedge clk); ack_v = 0;
    exp_flags[5] = 1'b0;
    chk("R6 ack clears", 64'(flags), 64'(exp_flags));
  endtask

  task automatic t_ack_vs_write();
    // same index: write wins
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = 8'h14; wdata = 32'h0000_0077;
    @(negedge clk); en = 1; ack_v = 1; ack_i = 5;
    @(negedge clk); sel = 0; en = 0; wr = 0; ack_v = 0;
    model[5] = 32'h77; exp_flags[5] = 1'b1;
    chk("R6 write beats ack", 64'(flags[5]), 64'd1);
    // different index: both act
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = 8'h0C; wdata = 32'h0000_0003;
    @(negedge clk); en = 1; ack_v = 1; ack_i = 0;
    @(negedge clk); sel = 0; en = 0; wr = 0; ack_v = 0;
    model[3] = 32'h3; exp_flags[3] = 1'b1; exp_flags[0] = 1'b0;
    chk("R6 split ack and write", 64'(flags), 64'(exp_flags));
    chk("R2 word3 stored", 64'(cfg_flat[3*32 +: 32]), 64'h3);
  endtask

  task automatic t_illegal();
    logic [31:0] rd; logic er, rdy;
    rd_addr(8'h78, rd, er);
    chk("R7 unmapped read err", {63'd0, er}, 64'd1);
    chk("R7 unmapped read zero", 64'(rd), 64'd0);
    xfer(1, 8'h15, 32'h1234_5678, rd, er, rdy);
    chk("R7 misaligned err", {63'd0, er}, 64'd1);
    xfer(1, 8'h70, 32'hFFFF_FFFF, rd, er, rdy);
    chk("R7 flags word ro", {63'd0, er}, 64'd1);
    xfer(1, 8'h80, 32'hFFFF_FFFF, rd, er, rdy);
    chk("R7 high write err", {63'd0, er}, 64'd1);
    chk("R7 cfg unchanged", {63'd0, cfg_flat == model_flat()}, 64'd1);
    chk("R7 flags unchanged", 64'(flags), 64'(exp_flags));
  endtask

  task automatic report(logic w, logic ok);
    @(negedge clk); rep_v = 1; rep_w = w; rep_ok = ok;
    @(negedge clk); rep_v = 0;
  endtask

  task automatic t_status();
    logic [31:0] rd; logic er;
    report(0, 1);
    rd_addr(8'h74, rd, er);
    chk("R8 read ok", 64'(rd), 64'h5);
    report(1, 0);
    rd_addr(8'h74, rd, er);
    chk("R8 write fail", 64'(rd), 64'h10D);
    report(1, 1);
    rd_addr(8'h74, rd, er);
    chk("R8 write ok", 64'(rd), 64'h10F);
    for (int k = 0; k < 260; k++) report(0, 0);
    rd_addr(8'h74, rd, er);
    chk("R8 fail count saturates", 64'(rd), 64'hFF0E);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    nerr++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    for (int i = 0; i < NC; i++) model[i] = '0;
    exp_flags = '0;
    repeat (3) @(negedge clk);
    rst = 0;
    t_reset();
    t_write_read();
    t_reserved();
    t_flags();
    t_ack();
    t_ack_vs_write();
    t_illegal();
    t_status();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule